// File: doc/BRIEF.md
# Effective Address Resolver

This block turns a 36-bit single-address instruction word into the 15-bit address of its operand. It can modify the base address with the contents of an index register, and it can follow a chain of indirect words of any length. Index registers are ordinary memory locations, so the block reads them, and every indirect word, through one synchronous read port. The read data arrives one clock after the request.

A controller presents the instruction word with a one-clock `start` strobe. At every level of the chain, the block first applies the index register named at that level, using a 15-bit ones'-complement adder with end-around carry. It then follows the indirect flag, if set, to the next word. When the chain ends, the block raises `done` for one clock. At the same time it presents the resolved address and the number of extra memory reads it used. Words in memory are only read and never rewritten.

Top module: `addr_resolver`

## Requirements
- R1: Bits are numbered with bit 0 as the most significant bit, which is vector bit 35. In that numbering, bit 6 (vector bit 29) is the indirect flag. Bits 9–17 (vector 26:18) are the index selector. Bits 21–35 (vector 14:0) are the 15-bit base address.
- R2: When the selector is zero and the indirect flag is clear, no read is issued. `done` rises one clock after `start`, with `eff_addr` equal to the base address and `extra_cycles` equal to 0.
- R3: A selector from 1 to 511 causes a read of the memory location with that number. The low 15 bits of the data are added to the current address in ones'-complement arithmetic: a carry out of bit 14 is added back into bit 0. An all-ones result is kept as all ones.
- R4: When the indirect flag is set, the indexed address is read. The word read supplies a new base address, index selector and indirect flag. Its index is applied first, and deferral repeats while its flag is set, with no depth limit.
- R5: Each index read and each indirect read adds one to `extra_cycles`. The time from the `start` edge to `done` is 1 + 2·N clocks for N reads.
- R6: `done` is high for exactly one clock. `eff_addr` and `extra_cycles` are valid in that clock.
- R7: `mem_rd_en` is high for one clock per read, only while busy, and never on two consecutive clocks. The data is taken in the following clock.
- R8: `start` is ignored while `busy` is high. The resolution in progress completes with its own result.
- R9: The opcode, the expansion bits (vector 17:15) and the upper 21 bits of an index register word have no effect on the result.
- R10: `extra_cycles` saturates at its maximum value (255 by default) on very long chains.
- R11: After reset, `busy`, `done` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock request strobe, taken while idle |
| instr | input | 36 | Instruction word to resolve |
| busy | output | 1 | Resolution in progress, including the done clock |
| done | output | 1 | One-clock completion pulse |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 15 | Memory read address |
| mem_rd_data | input | 36 | Read data, valid one clock after the request |
| eff_addr | output | 15 | Resolved operand address |
| extra_cycles | output | 8 | Number of extra memory reads, saturating |

## Verification
The bench targets the adder's corner cases: a negative index that must subtract through the end-around carry, a sum that wraps to plus one, and a sum that must stay at minus zero. A design without the wrap would be off by one, and a design that normalises minus zero would return 0. Mixed chains of indexing and deferral catch a design that skips the index at deeper levels or applies it in the wrong order. A chain longer than the counter range catches a counter that wraps instead of saturating. A `start` held during a busy resolution catches a design that restarts and reports the second word's address.

// File: rtl/addr_res_pkg.sv
package addr_res_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_INDEX = 2'd1,
      ST_INDIR = 2'd2,
      ST_DONE  = 2'd3
   } res_state_t;
endpackage

// File: rtl/word_fields.sv
module word_fields #(
   parameter int WORD_W    = 36,
   parameter int ADDR_W    = 15,
   parameter int OP_W      = 6,
   parameter int IDX_START = 9,
   parameter int IDX_W     = 9
) (
   input  logic [WORD_W-1:0] word,
   output logic              ind,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] base
);
   localparam int IND_POS = WORD_W - 1 - OP_W;
   localparam int IDX_HI  = WORD_W - 1 - IDX_START;
   localparam int IDX_LO  = IDX_HI - IDX_W + 1;

   assign ind  = word[IND_POS];
   assign idx  = word[IDX_HI:IDX_LO];
   assign base = word[ADDR_W-1:0];
endmodule

// File: rtl/oc_adder.sv
module oc_adder #(
   parameter int W            = 15,
   parameter bit CARRY_SELECT = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   logic [W:0] raw;
   assign raw = {1'b0, a} + {1'b0, b};

   generate
      if (CARRY_SELECT) begin : g_csel
         logic [W:0] raw_p1;
         assign raw_p1 = raw + {{W{1'b0}}, 1'b1};
         assign sum    = raw[W] ? raw_p1[W-1:0] : raw[W-1:0];
      end else begin : g_wrap
         assign sum = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
      end
   endgenerate
endmodule

// File: rtl/addr_resolver.sv
module addr_resolver
   import addr_res_pkg::*;
#(
   parameter int WORD_W       = 36,
   parameter int ADDR_W       = 15,
   parameter int OP_W         = 6,
   parameter int IDX_START    = 9,
   parameter int IDX_W        = 9,
   parameter int CNT_W        = 8,
   parameter bit CARRY_SELECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] instr,
   output logic              busy,
   output logic              done,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [WORD_W-1:0] mem_rd_data,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [CNT_W-1:0]  extra_cycles
);
   localparam int IDX_LO_POS = WORD_W - IDX_START - IDX_W;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (IDX_LO_POS < ADDR_W) begin : g_bad_layout
         $error("index field overlaps base address");
      end
      if (IDX_W >= ADDR_W) begin : g_bad_idx
         $error("index selector must be narrower than address");
      end
      if (IDX_START <= OP_W) begin : g_bad_flag
         $error("index field overlaps indirect flag");
      end
   endgenerate

   res_state_t        state_q;
   logic              phase_q;
   logic [ADDR_W-1:0] addr_q;
   logic [IDX_W-1:0]  idx_q;
   logic              ind_q;
   logic [CNT_W-1:0]  cnt_q;

   logic              in_ind, md_ind;
   logic [IDX_W-1:0]  in_idx, md_idx;
   logic [ADDR_W-1:0] in_base, md_base;
   logic [ADDR_W-1:0] idx_sum;
   logic [CNT_W-1:0]  cnt_next;

   word_fields #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .OP_W(OP_W),
                 .IDX_START(IDX_START), .IDX_W(IDX_W)) u_in_fields (
      .word(instr), .ind(in_ind), .idx(in_idx), .base(in_base));

   word_fields #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .OP_W(OP_W),
                 .IDX_START(IDX_START), .IDX_W(IDX_W)) u_md_fields (
      .word(mem_rd_data), .ind(md_ind), .idx(md_idx), .base(md_base));

   oc_adder #(.W(ADDR_W), .CARRY_SELECT(CARRY_SELECT)) u_add (
      .a(addr_q), .b(mem_rd_data[ADDR_W-1:0]), .sum(idx_sum));

   assign cnt_next = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= 1'b0;
         addr_q  <= '0;
         idx_q   <= '0;
         ind_q   <= 1'b0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  addr_q  <= in_base;
                  idx_q   <= in_idx;
                  ind_q   <= in_ind;
                  cnt_q   <= '0;
                  phase_q <= 1'b0;
                  if (in_idx != '0)  state_q <= ST_INDEX;
                  else if (in_ind)   state_q <= ST_INDIR;
                  else               state_q <= ST_DONE;
               end
            end
            ST_INDEX: begin
               if (!phase_q) begin
                  phase_q <= 1'b1;
               end else begin
                  phase_q <= 1'b0;
                  addr_q  <= idx_sum;
                  cnt_q   <= cnt_next;
                  state_q <= ind_q ? ST_INDIR : ST_DONE;
               end
            end
            ST_INDIR: begin
               if (!phase_q) begin
                  phase_q <= 1'b1;
               end else begin
                  phase_q <= 1'b0;
                  addr_q  <= md_base;
                  idx_q   <= md_idx;
                  ind_q   <= md_ind;
                  cnt_q   <= cnt_next;
                  if (md_idx != '0)  state_q <= ST_INDEX;
                  else if (md_ind)   state_q <= ST_INDIR;
                  else               state_q <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_rd_en   = ((state_q == ST_INDEX) || (state_q == ST_INDIR)) && !phase_q;
      mem_rd_addr = (state_q == ST_INDEX) ? {{(ADDR_W-IDX_W){1'b0}}, idx_q} : addr_q;
   end

   assign busy         = (state_q != ST_IDLE);
   assign done         = (state_q == ST_DONE);
   assign eff_addr     = addr_q;
   assign extra_cycles = cnt_q;
endmodule

// File: rtl/addr_resolver_chk.sv
module addr_resolver_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             mem_rd_en,
   input logic [CNT_W-1:0] extra_cycles
);
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_rd_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   p_rd_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> busy);

   p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(done)) |->
         (extra_cycles == $past(extra_cycles) ||
          extra_cycles == $past(extra_cycles) + {{(CNT_W-1){1'b0}}, 1'b1}));

   p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!done && !mem_rd_en));
endmodule

bind addr_resolver addr_resolver_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .mem_rd_en(mem_rd_en), .extra_cycles(extra_cycles));

// File: tb/addr_resolver_test.sv
module addr_resolver_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [35:0] instr = '0;
   logic        busy, done, mem_rd_en;
   logic [14:0] mem_rd_addr, eff_addr;
   logic [35:0] mem_rd_data = '0;
   logic [7:0]  extra_cycles;

   logic [35:0] mem [0:4095];
   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   addr_resolver uut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .busy(busy),
      .done(done), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .eff_addr(eff_addr), .extra_cycles(extra_cycles));

   always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:0]];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [35:0] mk(input logic [5:0] op, input logic ind,
                                      input logic [8:0] idx, input logic [2:0] ex,
                                      input logic [14:0] y);
      return {op, ind, 2'b00, idx, ex, y};
   endfunction

   function automatic logic [14:0] ocadd(input logic [14:0] a, input logic [14:0] b);
      logic [15:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[14:0] + {14'd0, s[15]};
   endfunction

   // Model from R1, R3, R4: returns -1 reads when the chain exceeds the bound
   task automatic model(input logic [35:0] w, output logic [14:0] a, output int reads);
      logic [8:0] ix;
      logic       fl;
      logic [35:0] d;
      a = w[14:0]; ix = w[26:18]; fl = w[29]; reads = 0;
      while (1) begin
         if (ix != 0) begin
            a = ocadd(a, mem[{3'd0, ix}][14:0]);
            reads++;
         end
         if (!fl) break;
         d = mem[a[11:0]];
         reads++;
         a = d[14:0]; ix = d[26:18]; fl = d[29];
         if (reads > 400) begin reads = -1; break; end
      end
   endtask

   task automatic run_case(input logic [35:0] w, input string tag);
      logic [14:0] ea;
      int n, lat, ec;
      model(w, ea, n);
      if (n < 0) return;
      @(negedge clk); start = 1'b1; instr = w;
      @(negedge clk); start = 1'b0; instr = $urandom;
      lat = 1;
      while (!done && lat < 2000) begin @(negedge clk); lat++; end
      ec = (n > 255) ? 255 : n;
      check(eff_addr == ea, {tag, " address"}, eff_addr, ea);
      check(extra_cycles == ec[7:0], {tag, " R5 count"}, extra_cycles, ec);
      check(lat == 1 + 2 * n, {tag, " R5 latency"}, lat, 1 + 2 * n);
      @(negedge clk);
      check(!done, {tag, " R6 pulse"}, done, 0);
   endtask

   initial begin
      logic [14:0] ea;
      int n, lat;
      void'($urandom(32'd2024));
      for (int i = 0; i < 4096; i++) begin
         mem[i] = {$urandom, $urandom};
         mem[i][29] = ($urandom % 8 == 0);
      end
      repeat (3) @(negedge clk);
      check(!busy && !done && !mem_rd_en, "R11 reset", {busy, done, mem_rd_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !mem_rd_en, "R11 idle", {busy, done, mem_rd_en}, 0);

      // R2 / R9: no index, no deferral, opcode and expansion bits set
      run_case(mk(6'o77, 1'b0, 9'd0, 3'b111, 15'h1234), "R2 R9 direct");
      // R3 negative index, upper index-register bits garbage (R9)
      mem[5] = {21'h1ABCDE, 15'h7FFC};
      run_case(mk(6'o40, 1'b0, 9'd5, 3'b000, 15'd10), "R3 R9 negative index");
      // R3 minus zero kept
      mem[6] = {21'h0, 15'h0001};
      run_case(mk(6'o20, 1'b0, 9'd6, 3'b000, 15'h7FFE), "R3 minus zero");
      // R3 end-around carry
      mem[7] = {21'h155555, 15'h4000};
      run_case(mk(6'o20, 1'b0, 9'd7, 3'b000, 15'h4000), "R3 end-around");
      // R4 single deferral
      mem[12'h800] = mk(6'o00, 1'b0, 9'd0, 3'b101, 15'h0ABC);
      run_case(mk(6'o24, 1'b1, 9'd0, 3'b000, 15'h0800), "R4 R1 one level");
      // R4 mixed chain: index, defer, index, defer
      mem[12'h8FD] = mk(6'o11, 1'b1, 9'd6, 3'b000, 15'h0C00);
      mem[12'hC01] = mk(6'o33, 1'b0, 9'd0, 3'b000, 15'h1555);
      run_case(mk(6'o24, 1'b1, 9'd5, 3'b000, 15'h0900), "R4 R1 mixed chain");
      // R10 saturation with a 260-step chain
      for (int i = 0; i < 260; i++)
         mem[12'hA00 + i] = mk(6'o00, (i != 259), 9'd0, 3'b000,
                               (i == 259) ? 15'h0321 : 15'(16'hA00 + i + 1));
      run_case(mk(6'o20, 1'b1, 9'd0, 3'b000, 15'h0A00), "R10 saturate");

      // R8: start held while busy must not restart
      model(mk(6'o24, 1'b1, 9'd5, 3'b000, 15'h0900), ea, n);
      @(negedge clk); start = 1'b1; instr = mk(6'o24, 1'b1, 9'd5, 3'b000, 15'h0900);
      @(negedge clk); instr = mk(6'o20, 1'b0, 9'd0, 3'b000, 15'h0077);
      @(negedge clk); start = 1'b0;
      lat = 2;
      while (!done && lat < 2000) begin @(negedge clk); lat++; end
      check(eff_addr == ea, "R8 address", eff_addr, ea);
      check(lat == 1 + 2 * n, "R8 latency", lat, 1 + 2 * n);
      @(negedge clk);

      // Random mix for R3 R4 R5 R7
      for (int k = 0; k < 300; k++) begin
         logic [8:0] ix;
         ix = ($urandom % 4 == 0) ? 9'd0 : 9'($urandom);
         run_case(mk(6'($urandom), 1'($urandom), ix, 3'($urandom), 15'($urandom)),
                  "R3 R4 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule